// File: doc/BRIEF.md
# Per-Rank Leaky-Bucket Error Tracker

This block counts correctable memory errors separately for each logical rank of one memory channel and lets those counts decay over time. Decay works in two stages. An external timer supplies a shared primary leak strobe as a single-cycle pulse. Each rank owns a small secondary divider that counts those strobes. When the divider reaches the rank's programmed ratio, it emits a secondary leak pulse that takes one off that rank's error count.

When an error pushes a rank's count above that rank's threshold, the block sets a sticky status bit for the rank and raises an interrupt request. It also captures the index of the failing device that reported the error. Software reads the captured device, clears the status bit by writing one to it, and can arm a per-rank tag-enable bit. A tag-enable bit can be armed once and stays armed until reset.

Top module: `rank_leak_tracker`

## Requirements
- R1: While `rst` is high at a clock edge, every counter, status bit, captured device, tag bit and `irq_o` becomes zero after that edge.
- R2: Each rank's 2-bit secondary counter goes up by one on every `prim_leak_i` pulse. Rank r is packed at bits [2r+1:2r] of both `sec_cnt_o` and `ratio_cfg_i`.
- R3: The ratio code maps 00 to 4 strobes, 01 to 1, 10 to 2 and 11 to 3. When the incremented secondary count reaches or passes this ratio, the counter returns to zero and that rank produces a leak pulse.
- R4: Each leak pulse lowers that rank's error count by exactly 1. A leak pulse at a count of zero has no effect.
- R5: A pulse on `err_valid_i` raises the error count of rank `err_rank_i` by 1. The count is at bits [CNT_W*r +: CNT_W] of `err_cnt_o`.
- R6: An error on a rank whose count is at its maximum (2^CNT_W-1) leaves the count at the maximum.
- R7: When an error and a leak pulse hit the same rank in the same cycle, the count is unchanged.
- R8: When an error on a rank whose status bit is clear leaves that rank's count above its threshold (`thresh_i` bits [CNT_W*r +: CNT_W]), the status bit `irq_sts_o[r]` is set and `err_dev_i` is captured in `fail_dev_o` bits [DEV_W*r +: DEV_W], both at the same edge. A cancelled error (R7) does not fire.
- R9: While a rank's status bit is set, its captured device does not change. A pulse on `sts_clr_i[r]` clears the bit, and further errors cannot set it again in that same cycle.
- R10: A pulse on `tag_set_i[r]` sets `tag_en_o[r]`. The bit stays set until reset. Later pulses have no effect.
- R11: `irq_o` is a registered OR of all status bits, one cycle behind `irq_sts_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prim_leak_i | input | 1 | Shared primary leak strobe, one cycle |
| ratio_cfg_i | input | 2*NUM_RANKS | Secondary ratio code per rank |
| thresh_i | input | CNT_W*NUM_RANKS | Error threshold per rank |
| err_valid_i | input | 1 | Correctable error event |
| err_rank_i | input | $clog2(NUM_RANKS) | Rank of the error |
| err_dev_i | input | DEV_W | Failing device index of the error |
| sts_clr_i | input | NUM_RANKS | Write-one-to-clear of status bits |
| tag_set_i | input | NUM_RANKS | Write-one arm of tag-enable bits |
| err_cnt_o | output | CNT_W*NUM_RANKS | Error count per rank |
| sec_cnt_o | output | 2*NUM_RANKS | Secondary counter per rank |
| irq_sts_o | output | NUM_RANKS | Sticky status per rank |
| fail_dev_o | output | DEV_W*NUM_RANKS | Captured failing device per rank |
| tag_en_o | output | NUM_RANKS | Tag-enable per rank |
| irq_o | output | 1 | Interrupt request |

## Verification
Counts, secondary counters, status bits, captured devices and tag bits all change at the first clock edge after the input that causes them. `irq_o` follows one edge after that. The bench drives inputs on the falling edge and steps its model once per rising edge. On the next falling edge it compares every output with the model, and the model's interrupt value is the OR of the status bits from the previous step. Directed phases cover saturation, cancellation and repeated tag writes, and random phases mix leaks, errors and clears.

// File: rtl/rank_leak_pkg.sv
package rank_leak_pkg;
  localparam int RATIO_W = 2;

  // Ratio code to strobe count: code 0 stands for four strobes.
  function automatic logic [RATIO_W:0] ratio_of(input logic [RATIO_W-1:0] code);
    if (code == '0) return 3'd4;
    return {1'b0, code};
  endfunction
endpackage

// File: rtl/leak_sec_div.sv
module leak_sec_div
  import rank_leak_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               strobe_i,
  input  logic [RATIO_W-1:0] code_i,
  output logic [RATIO_W-1:0] cnt_o,
  output logic               leak_o
);
  logic [RATIO_W-1:0] cnt_q;
  logic [RATIO_W:0]   nxt;

  always_comb begin
    nxt    = {1'b0, cnt_q} + 3'd1;
    leak_o = strobe_i && (nxt >= ratio_of(code_i));
  end

  always_ff @(posedge clk) begin
    if (rst)           cnt_q <= '0;
    else if (leak_o)   cnt_q <= '0;
    else if (strobe_i) cnt_q <= nxt[RATIO_W-1:0];
  end

  assign cnt_o = cnt_q;

  AST_LEAK_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
    leak_o |-> strobe_i);                                               // R3
  AST_ROLL_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    leak_o |=> (cnt_o == '0));                                          // R3
  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    !strobe_i |=> $stable(cnt_o));                                      // R2
endmodule

// File: rtl/leak_err_slot.sv
module leak_err_slot #(
  parameter int CNT_W = 8,
  parameter int DEV_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_i,
  input  logic             dec_i,
  input  logic [DEV_W-1:0] dev_i,
  input  logic [CNT_W-1:0] thresh_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             sts_o,
  output logic [DEV_W-1:0] dev_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sts_q, fire;
  logic [DEV_W-1:0] dev_q;

  always_comb begin
    cnt_d = cnt_q;
    if (inc_i && !dec_i && cnt_q != CNT_MAX)   cnt_d = cnt_q + 1'b1;
    else if (dec_i && !inc_i && cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    fire = inc_i && !dec_i && !sts_q && (cnt_d > thresh_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      sts_q <= 1'b0;
      dev_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      sts_q <= fire || (sts_q && !clr_i);
      if (fire) dev_q <= dev_i;
    end
  end

  assign cnt_o = cnt_q;
  assign sts_o = sts_q;
  assign dev_o = dev_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (cnt_o == CNT_MAX && inc_i && !dec_i) |=> (cnt_o == CNT_MAX));      // R6
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (cnt_o == '0 && dec_i && !inc_i) |=> (cnt_o == '0));                // R4
  AST_CANCEL: assert property (@(posedge clk) disable iff (rst)
    (inc_i && dec_i) |=> $stable(cnt_o));                               // R7
  AST_DEV_FROZEN: assert property (@(posedge clk) disable iff (rst)
    sts_o |=> $stable(dev_o));                                          // R9
  AST_STS_STICKY: assert property (@(posedge clk) disable iff (rst)
    (sts_o && !clr_i) |=> sts_o);                                       // R9
endmodule

// File: rtl/rank_leak_tracker.sv
module rank_leak_tracker
  import rank_leak_pkg::*;
#(
  parameter int NUM_RANKS = 8,
  parameter int CNT_W     = 8,
  parameter int DEV_W     = 5,
  localparam int RANK_W   = $clog2(NUM_RANKS)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         prim_leak_i,
  input  logic [RATIO_W*NUM_RANKS-1:0] ratio_cfg_i,
  input  logic [CNT_W*NUM_RANKS-1:0]   thresh_i,
  input  logic                         err_valid_i,
  input  logic [RANK_W-1:0]            err_rank_i,
  input  logic [DEV_W-1:0]             err_dev_i,
  input  logic [NUM_RANKS-1:0]         sts_clr_i,
  input  logic [NUM_RANKS-1:0]         tag_set_i,
  output logic [CNT_W*NUM_RANKS-1:0]   err_cnt_o,
  output logic [RATIO_W*NUM_RANKS-1:0] sec_cnt_o,
  output logic [NUM_RANKS-1:0]         irq_sts_o,
  output logic [DEV_W*NUM_RANKS-1:0]   fail_dev_o,
  output logic [NUM_RANKS-1:0]         tag_en_o,
  output logic                         irq_o
);
  logic [NUM_RANKS-1:0] leak_w, inc_w;
  logic [NUM_RANKS-1:0] tag_q;
  logic                 irq_q;

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    assign inc_w[r] = err_valid_i && (err_rank_i == RANK_W'(r));

    leak_sec_div u_div (
      .clk      (clk),
      .rst      (rst),
      .strobe_i (prim_leak_i),
      .code_i   (ratio_cfg_i[RATIO_W*r +: RATIO_W]),
      .cnt_o    (sec_cnt_o[RATIO_W*r +: RATIO_W]),
      .leak_o   (leak_w[r])
    );

    leak_err_slot #(.CNT_W(CNT_W), .DEV_W(DEV_W)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .inc_i    (inc_w[r]),
      .dec_i    (leak_w[r]),
      .dev_i    (err_dev_i),
      .thresh_i (thresh_i[CNT_W*r +: CNT_W]),
      .clr_i    (sts_clr_i[r]),
      .cnt_o    (err_cnt_o[CNT_W*r +: CNT_W]),
      .sts_o    (irq_sts_o[r]),
      .dev_o    (fail_dev_o[DEV_W*r +: DEV_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q <= '0;
      irq_q <= 1'b0;
    end else begin
      tag_q <= tag_q | tag_set_i;
      irq_q <= |irq_sts_o;
    end
  end

  assign tag_en_o = tag_q;
  assign irq_o    = irq_q;

  AST_ONE_INC: assert property (@(posedge clk) disable iff (rst)
    $onehot0(inc_w));                                                   // R5
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (|irq_sts_o) |=> irq_o);                                            // R11
  AST_IRQ_DROPS: assert property (@(posedge clk) disable iff (rst)
    (irq_sts_o == '0) |=> !irq_o);                                      // R11
  AST_TAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (tag_en_o != '0) |=> ((tag_en_o & $past(tag_en_o)) == $past(tag_en_o))); // R10
endmodule

// File: tb/rank_leak_tracker_tb_top.sv
module rank_leak_tracker_tb_top;
  localparam int NR = 8;
  localparam int CW = 8;
  localparam int DW = 5;
  localparam int RW = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst;
  logic             prim;
  logic [2*NR-1:0]  ratio;
  logic [CW*NR-1:0] thresh;
  logic             ev;
  logic [RW-1:0]    ev_rank;
  logic [DW-1:0]    ev_dev;
  logic [NR-1:0]    clr, tset;
  logic [CW*NR-1:0] cnt_o;
  logic [2*NR-1:0]  sec_o;
  logic [NR-1:0]    sts_o, tag_o;
  logic [DW*NR-1:0] dev_o;
  logic             irq_o;

  rank_leak_tracker #(.NUM_RANKS(NR), .CNT_W(CW), .DEV_W(DW)) dut_i (
    .clk(clk), .rst(rst), .prim_leak_i(prim), .ratio_cfg_i(ratio),
    .thresh_i(thresh), .err_valid_i(ev), .err_rank_i(ev_rank),
    .err_dev_i(ev_dev), .sts_clr_i(clr), .tag_set_i(tset),
    .err_cnt_o(cnt_o), .sec_cnt_o(sec_o), .irq_sts_o(sts_o),
    .fail_dev_o(dev_o), .tag_en_o(tag_o), .irq_o(irq_o)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  int m_cnt[NR], m_sec[NR], m_dev[NR];
  bit m_sts[NR], m_tag[NR], m_irq;

  task automatic model_reset();
    for (int r = 0; r < NR; r++) begin
      m_cnt[r] = 0; m_sec[r] = 0; m_dev[r] = 0; m_sts[r] = 0; m_tag[r] = 0;
    end
    m_irq = 0;
  endtask

  function automatic int ratio_n(int code);
    return (code == 0) ? 4 : code;
  endfunction

  task automatic model_step();
    bit any = 0;
    if (rst) begin model_reset(); return; end
    for (int r = 0; r < NR; r++) any |= m_sts[r];
    m_irq = any;                                     // R11 one edge behind
    for (int r = 0; r < NR; r++) begin
      bit leak = 0, inc, fire;
      int nxt;
      int nc;
      if (prim) begin
        nxt = m_sec[r] + 1;
        leak = (nxt >= ratio_n(int'(ratio[2*r +: 2])));
        m_sec[r] = leak ? 0 : (nxt % 4);
      end
      inc = ev && (int'(ev_rank) == r);
      nc = m_cnt[r];
      if (inc && !leak && nc < (1 << CW) - 1) nc++;
      else if (leak && !inc && nc > 0) nc--;
      m_cnt[r] = nc;
      fire = inc && !leak && !m_sts[r] && (nc > int'(thresh[CW*r +: CW]));
      if (fire) m_dev[r] = int'(ev_dev);
      m_sts[r] = fire || (m_sts[r] && !clr[r]);
      m_tag[r] = m_tag[r] || tset[r];
    end
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare();
    for (int r = 0; r < NR; r++) begin
      chk($sformatf("R2/R3 sec_cnt rank%0d", r), int'(sec_o[2*r +: 2]), m_sec[r]);
      chk($sformatf("R4/R5/R6/R7 err_cnt rank%0d", r), int'(cnt_o[CW*r +: CW]), m_cnt[r]);
      chk($sformatf("R8/R9 status rank%0d", r), int'(sts_o[r]), int'(m_sts[r]));
      chk($sformatf("R8/R9 fail_dev rank%0d", r), int'(dev_o[DW*r +: DW]), m_dev[r]);
      chk($sformatf("R10 tag_en rank%0d", r), int'(tag_o[r]), int'(m_tag[r]));
    end
    chk("R11 irq", int'(irq_o), int'(m_irq));
  endtask

  task automatic tick();
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic idle_inputs();
    prim = 0; ev = 0; ev_rank = '0; ev_dev = '0; clr = '0; tset = '0;
  endtask

  initial begin
    void'($urandom(32'h1EA4));
    rst = 1; idle_inputs();
    ratio = 16'b11_10_01_00_11_10_01_00;
    thresh = '1;
    @(negedge clk);
    tick(); tick();
    // R1: reset state
    chk("R1 reset err_cnt", int'(|cnt_o), 0);
    chk("R1 reset status/tag/irq", int'(|{sts_o, tag_o, irq_o, sec_o}), 0);
    rst = 0;

    // R2/R3: strobes only, all four ratio codes present
    for (int i = 0; i < 12; i++) begin prim = 1; tick(); end
    idle_inputs();

    // R6: saturate rank 3 with no leaks
    for (int i = 0; i < 300; i++) begin
      ev = 1; ev_rank = 3'd3; ev_dev = DW'(i); tick();
    end
    chk("R6 saturated count", int'(cnt_o[CW*3 +: CW]), (1 << CW) - 1);

    // R7: ratio 01 on rank 1 so every strobe leaks, together with an error
    ratio[3:2] = 2'b01;
    ev = 1; ev_rank = 3'd1; prim = 0; tick();
    ev = 1; ev_rank = 3'd1; prim = 1; tick();
    chk("R7 cancel keeps count", int'(cnt_o[CW*1 +: CW]), 1);
    idle_inputs();

    // R4: leak at zero on rank 0 has no effect
    ratio[1:0] = 2'b01;
    prim = 1; tick(); tick();
    chk("R4 leak at zero", int'(cnt_o[CW*0 +: CW]), 0);
    idle_inputs();

    // R8/R9: threshold 2 on rank 5, fire then freeze, then clear
    thresh[CW*5 +: CW] = 8'd2;
    for (int i = 0; i < 5; i++) begin ev = 1; ev_rank = 3'd5; ev_dev = DW'(10 + i); tick(); end
    idle_inputs();
    chk("R8 captured device", int'(dev_o[DW*5 +: DW]), 12);
    tick();
    chk("R11 irq asserted", int'(irq_o), 1);
    clr[5] = 1; ev = 1; ev_rank = 3'd5; ev_dev = 5'd30; tick();
    chk("R9 cleared status", int'(sts_o[5]), 0);
    idle_inputs();

    // R10: arm tag twice
    tset[2] = 1; tick(); tick();
    idle_inputs(); tick();
    chk("R10 tag stays set", int'(tag_o[2]), 1);

    // random phase
    for (int r = 0; r < NR; r++) thresh[CW*r +: CW] = CW'($urandom_range(0, 12));
    for (int i = 0; i < 4000; i++) begin
      if (i % 500 == 0) ratio = 16'($urandom);
      prim = ($urandom_range(0, 3) == 0);
      ev = $urandom_range(0, 1) == 1;
      ev_rank = RW'($urandom_range(0, NR - 1));
      ev_dev = DW'($urandom);
      for (int r = 0; r < NR; r++) clr[r] = ($urandom_range(0, 15) == 0);
      tset = ($urandom_range(0, 63) == 0) ? NR'($urandom) : '0;
      tick();
    end
    idle_inputs();
    rst = 1; tick();
    rst = 0;
    chk("R1 reset after traffic", int'(|{cnt_o, sts_o, tag_o, dev_o}), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule